// File: doc/BRIEF.md
# SMBus Host Transaction Controller

This block is the host side of a system management bus. Software fills a small byte-addressed register set with a target address and direction bit, a command byte and up to two data bytes. It then writes a control byte that holds a protocol code and a start bit. A three-state sequencer hands one request to a serial bus engine over a valid/ready channel. It waits for the engine's single response and then sets sticky status flags. Software clears those flags by writing ones to them.

The serial engine sits outside this block. The request channel follows valid/ready rules. Once `req_valid` is high, every `req_*` field holds steady until the cycle in which `req_ready` is also high, and `req_valid` then drops. A kill withdraws the request without a handshake, and `req_abort` pulses for one cycle when that happens. The response channel has no ready signal. A `rsp_valid` pulse is taken only while the sequencer is waiting for a response, and a pulse at any other time has no effect. Four protocols are carried out: quick, byte, byte-data and word-data. A start with any other protocol code fails at once and makes no bus request.

Register map (offset: use). 0 status, 2 control, 3 command, 4 target, 5 data low, 6 data high, 13 auxiliary control. Reads of any other offset return 0.

Top module: `smbh_host_top`

## Requirements
- R1: After reset every register reads 0, and `req_valid` and `req_abort` are low.
- R2: A control write with bit 6 set, while idle, starts a transaction when bits 5:2 hold 0, 1, 2 or 3 (codes 0x00 quick, 0x04 byte, 0x08 byte-data, 0x0C word-data). From the next cycle, status bit 0 (busy) reads 1 and `req_valid` is high. The request then carries: `req_target` equal to the target register, `req_cmd` equal to the command register, `req_kind` equal to the field value, and `req_wdata` equal to {data high, data low}.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field stay unchanged. After a cycle with both high, `req_valid` is low.
- R4: A response with neither error flag clears busy and sets status bit 1 (done) on the same clock edge.
- R5: When target bit 0 is 1 (read) and the transfer succeeds, byte and byte-data load `rsp_rdata[7:0]` into data low, and word-data also loads `rsp_rdata[15:8]` into data high. Write transfers, quick transfers and failed transfers leave both data registers unchanged.
- R6: A response with `rsp_nack` sets status bit 2. A response with `rsp_arb_lost` sets status bit 3. When both are present, only bit 3 is set. Either one clears busy.
- R7: A control write with bit 1 set while busy ends the transaction at that edge: busy clears, status bit 4 (failed) sets, `req_valid` drops and `req_abort` pulses. The same write while idle leaves the status unchanged.
- R8: Writing status with a 1 in bit 1, 2, 3 or 4 clears that flag. A 0 leaves the flag as it is.
- R9: While busy, a further start is ignored. Writes to target, command, data, control and auxiliary control are also ignored.
- R10: A start whose bits 5:2 hold 4 to 15 (for example 0x10, 0x14, 0x18, 0x34 or 0x38) sets status bit 4 at the next edge. Busy stays 0 and no request is made.
- R11: `req_pec` is high when control bit 7 or auxiliary control bit 0 is set, except for a quick transfer, where it is 0.
- R12: Control reads back bits 7 and 5:2 as last written, with bits 6 and 1 reading 0. Auxiliary control reads back bits 1:0.
- R13: A `rsp_valid` pulse that arrives while idle, or while the request is still waiting for `req_ready`, changes no flag and no data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write offset |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 4 | Read offset |
| reg_rdata | output | 8 | Read data, combinational from `reg_raddr` |
| req_valid | output | 1 | Request to the bus engine is valid |
| req_ready | input | 1 | Bus engine accepts the request |
| req_target | output | 8 | Target address in 7:1, read bit in 0 |
| req_cmd | output | 8 | Command byte |
| req_kind | output | 2 | 0 quick, 1 byte, 2 byte-data, 3 word-data |
| req_wdata | output | 16 | Write data, high byte in 15:8 |
| req_pec | output | 1 | Packet error code requested |
| req_abort | output | 1 | One-cycle pulse: request withdrawn by kill |
| rsp_valid | input | 1 | Response pulse from the bus engine |
| rsp_nack | input | 1 | Target did not acknowledge |
| rsp_arb_lost | input | 1 | Arbitration was lost |
| rsp_rdata | input | 16 | Read data, high byte in 15:8 |

## Verification
A sequencer stuck away from idle would show as busy that never falls and a start that no longer raises `req_valid`. A sequencer that returned to idle too early would drop busy one edge after the handshake with no flag set. Either case is visible in the status read taken in the cycle after the response or the kill. A wrong flag-update term would leave a wrong value at status bits 1 to 4 in the cycle after the event, or after the clearing write. A broken register lock would show up the same way through the target or control readback during a transaction, or through a changed request field on the next edge.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam int OFF_STS = 0;
  localparam int OFF_CTL = 2;
  localparam int OFF_CMD = 3;
  localparam int OFF_TGT = 4;
  localparam int OFF_DLO = 5;
  localparam int OFF_DHI = 6;
  localparam int OFF_AUX = 13;

  localparam int BIT_BUSY = 0;
  localparam int BIT_DONE = 1;
  localparam int BIT_DEV  = 2;
  localparam int BIT_BUS  = 3;
  localparam int BIT_FAIL = 4;

  localparam int CBIT_KILL  = 1;
  localparam int CBIT_START = 6;
  localparam int CBIT_PEC   = 7;

  typedef enum logic [1:0] {
    K_QUICK = 2'd0,
    K_BYTE  = 2'd1,
    K_BDATA = 2'd2,
    K_WORD  = 2'd3
  } xact_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/smbh_regfile.sv
module smbh_regfile
  import smbh_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          busy,
  input  logic          ev_ok,
  input  logic          ev_nack,
  input  logic          ev_arb,
  input  logic          ev_fail,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [2*DW-1:0] rx_data,
  output logic          go,
  output logic          bad_go,
  output logic          kill,
  output xact_kind_e    kind,
  output logic [DW-1:0] tgt,
  output logic [DW-1:0] cmd,
  output logic [2*DW-1:0] wdata,
  output logic          pec,
  output logic [3:0]    flags
);
  logic [DW-1:0] tgt_q, cmd_q, dlo_q, dhi_q;
  logic [3:0]    proto_q;
  logic          pecf_q;
  logic [1:0]    aux_q;
  logic          f_done, f_dev, f_bus, f_fail;

  logic sel_sts, sel_ctl, sel_cmd, sel_tgt, sel_dlo, sel_dhi, sel_aux;
  logic code_ok;
  logic [DW-1:0] clr;

  assign sel_sts = wr_en && (wr_addr == AW'(OFF_STS));
  assign sel_ctl = wr_en && (wr_addr == AW'(OFF_CTL));
  assign sel_cmd = wr_en && (wr_addr == AW'(OFF_CMD));
  assign sel_tgt = wr_en && (wr_addr == AW'(OFF_TGT));
  assign sel_dlo = wr_en && (wr_addr == AW'(OFF_DLO));
  assign sel_dhi = wr_en && (wr_addr == AW'(OFF_DHI));
  assign sel_aux = wr_en && (wr_addr == AW'(OFF_AUX));

  // protocol field occupies bits 5:2; only values 0..3 are carried out
  assign code_ok = (wr_data[5:4] == 2'b00);
  assign go      = sel_ctl && wr_data[CBIT_START] && !busy && code_ok;
  assign bad_go  = sel_ctl && wr_data[CBIT_START] && !busy && !code_ok;
  assign kill    = sel_ctl && wr_data[CBIT_KILL] && busy;
  assign clr     = sel_sts ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q   <= '0;
      cmd_q   <= '0;
      dlo_q   <= '0;
      dhi_q   <= '0;
      proto_q <= '0;
      pecf_q  <= 1'b0;
      aux_q   <= '0;
    end else begin
      if (!busy) begin
        if (sel_tgt) tgt_q <= wr_data;
        if (sel_cmd) cmd_q <= wr_data;
        if (sel_dlo) dlo_q <= wr_data;
        if (sel_dhi) dhi_q <= wr_data;
        if (sel_aux) aux_q <= wr_data[1:0];
        if (sel_ctl) begin
          proto_q <= wr_data[5:2];
          pecf_q  <= wr_data[CBIT_PEC];
        end
      end
      if (ld_lo) dlo_q <= rx_data[DW-1:0];
      if (ld_hi) dhi_q <= rx_data[2*DW-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_done <= 1'b0;
      f_dev  <= 1'b0;
      f_bus  <= 1'b0;
      f_fail <= 1'b0;
    end else begin
      f_done <= (f_done & ~clr[BIT_DONE]) | ev_ok;
      f_dev  <= (f_dev  & ~clr[BIT_DEV])  | ev_nack;
      f_bus  <= (f_bus  & ~clr[BIT_BUS])  | ev_arb;
      f_fail <= (f_fail & ~clr[BIT_FAIL]) | ev_fail | bad_go;
    end
  end

  assign kind  = xact_kind_e'(proto_q[1:0]);
  assign tgt   = tgt_q;
  assign cmd   = cmd_q;
  assign wdata = {dhi_q, dlo_q};
  assign pec   = (pecf_q | aux_q[0]) && (kind != K_QUICK);
  assign flags = {f_fail, f_bus, f_dev, f_done};

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AW'(OFF_STS): rd_data = {3'b000, f_fail, f_bus, f_dev, f_done, busy};
      AW'(OFF_CTL): rd_data = {pecf_q, 1'b0, proto_q, 2'b00};
      AW'(OFF_CMD): rd_data = cmd_q;
      AW'(OFF_TGT): rd_data = tgt_q;
      AW'(OFF_DLO): rd_data = dlo_q;
      AW'(OFF_DHI): rd_data = dhi_q;
      AW'(OFF_AUX): rd_data = {{(DW-2){1'b0}}, aux_q};
      default:      rd_data = '0;
    endcase
  end

  // R8: a one written to the done position clears it unless a completion lands
  a_r8_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sts && wr_data[BIT_DONE] && !ev_ok |=> !f_done);
  // R9: request fields are frozen for the whole transaction
  a_r9_fields_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tgt_q) && $stable(cmd_q) && $stable(proto_q));
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          kill,
  input  xact_kind_e    kind,
  input  logic          rd_dir,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  input  logic          rsp_arb,
  output logic          busy,
  output logic          req_valid,
  output logic          abort,
  output logic          ev_ok,
  output logic          ev_nack,
  output logic          ev_arb,
  output logic          ev_fail,
  output logic          ld_lo,
  output logic          ld_hi
);
  seq_state_e state_q;
  logic take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else if (kill) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE: if (go)        state_q <= S_REQ;
        S_REQ:  if (req_ready) state_q <= S_WAIT;
        S_WAIT: if (rsp_valid) state_q <= S_IDLE;
        default:               state_q <= S_IDLE;
      endcase
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign req_valid = (state_q == S_REQ);
  assign abort     = kill;
  assign take      = (state_q == S_WAIT) && rsp_valid && !kill;
  assign ev_arb    = take && rsp_arb;
  assign ev_nack   = take && !rsp_arb && rsp_nack;
  assign ev_ok     = take && !rsp_arb && !rsp_nack;
  assign ev_fail   = kill;
  assign ld_lo     = ev_ok && rd_dir && (kind != K_QUICK);
  assign ld_hi     = ev_ok && rd_dir && (kind == K_WORD);

  // R3: an offered request stays up until accepted or killed
  a_r3_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !kill |=> req_valid);
  // R3: handshake retires the request
  a_r3_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_valid);
  // R9: no second start is accepted during a transaction
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !go);
endmodule

// File: rtl/smbh_host_top.sv
module smbh_host_top
  import smbh_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_waddr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [AW-1:0] reg_raddr,
  output logic [DW-1:0] reg_rdata,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_target,
  output logic [DW-1:0] req_cmd,
  output logic [1:0]    req_kind,
  output logic [2*DW-1:0] req_wdata,
  output logic          req_pec,
  output logic          req_abort,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  input  logic          rsp_arb_lost,
  input  logic [2*DW-1:0] rsp_rdata
);
  logic busy, go, bad_go, kill;
  logic ev_ok, ev_nack, ev_arb, ev_fail, ld_lo, ld_hi;
  xact_kind_e kind;
  logic [3:0] flags;

  smbh_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .rd_addr(reg_raddr), .rd_data(reg_rdata),
    .busy(busy), .ev_ok(ev_ok), .ev_nack(ev_nack), .ev_arb(ev_arb),
    .ev_fail(ev_fail), .ld_lo(ld_lo), .ld_hi(ld_hi), .rx_data(rsp_rdata),
    .go(go), .bad_go(bad_go), .kill(kill), .kind(kind),
    .tgt(req_target), .cmd(req_cmd), .wdata(req_wdata), .pec(req_pec),
    .flags(flags)
  );

  smbh_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(go), .kill(kill), .kind(kind), .rd_dir(req_target[0]),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_nack(rsp_nack),
    .rsp_arb(rsp_arb_lost),
    .busy(busy), .req_valid(req_valid), .abort(req_abort),
    .ev_ok(ev_ok), .ev_nack(ev_nack), .ev_arb(ev_arb), .ev_fail(ev_fail),
    .ld_lo(ld_lo), .ld_hi(ld_hi)
  );

  assign req_kind = kind;

  // R4 R6: busy never falls without a flag explaining why
  a_r4_drop_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (flags != 4'b0000));
  // R7: kill ends the transaction with the failed flag
  a_r7_kill_fails: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !busy && flags[3]);
  // R10: unsupported code fails without going busy
  a_r10_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    bad_go |=> !busy && !req_valid && flags[3]);
endmodule

// File: tb/smbh_host_top_tb_top.sv
`timescale 1ns/1ps
module smbh_host_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [7:0]  reg_rdata;
  logic        req_valid, req_ready = 1'b0;
  logic [7:0]  req_target, req_cmd;
  logic [1:0]  req_kind;
  logic [15:0] req_wdata;
  logic        req_pec, req_abort;
  logic        rsp_valid = 1'b0, rsp_nack = 1'b0, rsp_arb_lost = 1'b0;
  logic [15:0] rsp_rdata = '0;

  int total = 0;
  int bad = 0;
  logic [7:0]  v, ta, cm, d0, d1, ctl;
  logic [15:0] rdv;
  logic        pecb;

  always #2.5 clk = ~clk;

  smbh_host_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_target(req_target),
    .req_cmd(req_cmd), .req_kind(req_kind), .req_wdata(req_wdata),
    .req_pec(req_pec), .req_abort(req_abort), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_arb_lost(rsp_arb_lost), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] q);
    reg_raddr = a;
    #0.5;
    q = reg_rdata;
  endtask

  task automatic respond(input logic nk, input logic al, input logic [15:0] data);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_nack = nk; rsp_arb_lost = al; rsp_rdata = data;
    @(negedge clk);
    rsp_valid = 1'b0; rsp_nack = 1'b0; rsp_arb_lost = 1'b0;
  endtask

  task automatic accept();
    @(negedge clk);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
  endtask

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1 reg after reset", v, 0);
    end
    chk("R1 req_valid after reset", req_valid, 0);
    chk("R1 req_abort after reset", req_abort, 0);

    // sweep: protocol x direction x outcome
    for (int kd = 0; kd < 4; kd++)
      for (int rw = 0; rw < 2; rw++)
        for (int oc = 0; oc < 3; oc++) begin
          ta   = {7'(8'h10 + kd*6 + rw*3 + oc), rw[0]};
          cm   = 8'(8'h5A + kd*17 + oc);
          d0   = 8'(8'h30 + kd*8 + oc);
          d1   = 8'(8'hC0 + rw*4 + oc);
          pecb = (oc == 1);
          ctl  = {pecb, 1'b1, 2'b00, 2'(kd), 2'b00};
          rdv  = 16'(16'hB700 + kd*37 + rw*11 + oc*5);
          wr(4'd3, cm); wr(4'd4, ta); wr(4'd5, d0); wr(4'd6, d1);
          // R13: stray response while idle
          respond(1'b0, 1'b0, 16'hFFFF);
          rd(4'd0, v); chk("R13 idle response ignored", v, 0);
          wr(4'd2, ctl);
          rd(4'd0, v); chk("R2 busy after start", v, 8'h01);
          chk("R2 req_valid", req_valid, 1);
          chk("R2 req_target", req_target, ta);
          chk("R2 req_cmd", req_cmd, cm);
          chk("R2 req_kind", req_kind, kd);
          chk("R2 req_wdata", req_wdata, {d1, d0});
          chk("R11 req_pec", req_pec, (kd != 0) && pecb);
          rd(4'd2, v); chk("R12 ctl readback", v, {pecb, 1'b0, 2'b00, 2'(kd), 2'b00});
          if (oc == 2) begin
            // R13: response before handshake ignored
            respond(1'b0, 1'b0, 16'hEEEE);
          end else begin
            @(negedge clk);
          end
          chk("R3 valid held", req_valid, 1);
          chk("R3 target held", req_target, ta);
          chk("R3 wdata held", req_wdata, {d1, d0});
          rd(4'd0, v); chk("R13 early response ignored", v, 8'h01);
          accept();
          chk("R3 valid drops", req_valid, 0);
          @(negedge clk);
          rd(4'd0, v); chk("R4 still busy while waiting", v, 8'h01);
          respond(oc == 1, oc == 2, rdv);
          rd(4'd0, v);
          chk("R4 R6 status after response", v, (oc == 0) ? 8'h02 : (oc == 1) ? 8'h04 : 8'h08);
          rd(4'd5, v);
          chk("R5 data low", v, (oc == 0 && rw == 1 && kd != 0) ? rdv[7:0] : d0);
          rd(4'd6, v);
          chk("R5 data high", v, (oc == 0 && rw == 1 && kd == 3) ? rdv[15:8] : d1);
          wr(4'd0, 8'h00);
          rd(4'd0, v);
          chk("R8 zero write keeps flag", v, (oc == 0) ? 8'h02 : (oc == 1) ? 8'h04 : 8'h08);
          wr(4'd0, 8'hFF);
          rd(4'd0, v); chk("R8 w1c clears", v, 0);
        end

    // R6: both error inputs, arbitration wins
    wr(4'd4, 8'h21); wr(4'd2, 8'h48);
    accept();
    respond(1'b1, 1'b1, 16'h1234);
    rd(4'd0, v); chk("R6 arb precedence", v, 8'h08);
    rd(4'd5, v); chk("R6 no data load on error", v, 8'h30 + 8'd24 + 8'd2);
    wr(4'd0, 8'h08);
    rd(4'd0, v); chk("R8 clear bus bit", v, 0);

    // R7: kill during request phase
    wr(4'd4, 8'hA0); wr(4'd2, 8'h4C);
    @(negedge clk);
    reg_wr = 1'b1; reg_waddr = 4'd2; reg_wdata = 8'h02;
    #0.5;
    chk("R7 abort pulse", req_abort, 1);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R7 request withdrawn", req_valid, 0);
    chk("R7 abort ends", req_abort, 0);
    rd(4'd0, v); chk("R7 kill status", v, 8'h10);
    wr(4'd0, 8'h10);

    // R7: kill during wait, late response then ignored (R13)
    wr(4'd2, 8'h44);
    accept();
    wr(4'd2, 8'h02);
    rd(4'd0, v); chk("R7 kill in wait", v, 8'h10);
    respond(1'b0, 1'b0, 16'h5555);
    rd(4'd0, v); chk("R13 response after kill ignored", v, 8'h10);
    wr(4'd0, 8'h10);
    // R7: kill while idle
    wr(4'd2, 8'h02);
    rd(4'd0, v); chk("R7 idle kill no effect", v, 0);
    rd(4'd2, v); chk("R12 kill bit reads 0", v, 0);

    // R9: writes and restart during a transaction
    wr(4'd4, 8'h33); wr(4'd2, 8'h0C | 8'h40);
    accept();
    wr(4'd2, 8'hC4); wr(4'd4, 8'h55); wr(4'd3, 8'h77); wr(4'd13, 8'h01);
    rd(4'd2, v); chk("R9 ctl locked", v, 8'h0C);
    rd(4'd4, v); chk("R9 target locked", v, 8'h33);
    rd(4'd13, v); chk("R9 aux locked", v, 0);
    rd(4'd0, v); chk("R9 still one transaction", v, 8'h01);
    chk("R9 no new request", req_valid, 0);
    respond(1'b0, 1'b0, 16'hABCD);
    rd(4'd0, v); chk("R9 completes normally", v, 8'h02);
    rd(4'd5, v); chk("R5 word read low", v, 8'hCD);
    rd(4'd6, v); chk("R5 word read high", v, 8'hAB);
    wr(4'd0, 8'h02);

    // R10: unsupported codes
    for (int f = 4; f < 16; f++) begin
      wr(4'd2, {1'b0, 1'b1, 4'(f), 2'b00});
      chk("R10 no request", req_valid, 0);
      rd(4'd0, v); chk("R10 failed flag only", v, 8'h10);
      rd(4'd2, v); chk("R12 field readback", v, {2'b00, 4'(f), 2'b00});
      wr(4'd0, 8'h10);
    end

    // R11: auxiliary CRC bit drives pec; quick forces 0
    wr(4'd13, 8'h03);
    rd(4'd13, v); chk("R12 aux readback", v, 8'h03);
    wr(4'd2, 8'h44);
    chk("R11 aux pec on byte", req_pec, 1);
    accept(); respond(1'b0, 1'b0, 16'h0);
    wr(4'd2, 8'h40);
    chk("R11 quick pec off", req_pec, 0);
    accept(); respond(1'b0, 1'b0, 16'h0);
    rd(4'd0, v); chk("R4 quick done", v, 8'h02);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule